// File: doc/BRIEF.md
# Serial Wiper Register with Cascade Output

This block is the digital front end of a 256-step programmable resistor. A host writes an 8-bit wiper code over a three-wire serial link made of an active-low select, a serial clock and a data line. Bits enter an input shift register, most significant bit first, on rising serial clock edges while select is low. The wiper code changes only when select returns high. At that point the shift register is copied into the wiper latch. The latch drives an 8-bit code output and a 256-bit one-hot tap select.

Bits that leave the top of the shift register appear on a serial output, so several of these blocks can be chained. The output models an open-drain pin. An enable is active while the line must be pulled low and is released for a 1. All three serial inputs are resynchronised to a faster system clock, and their edges are detected in that clock domain.

Top module: `serial_wiper`

## Requirements
- R1: After reset the wiper code is 0x80, tap_sel has only bit 128 set, and sdo_oe is low, because the shift register resets to all ones.
- R2: A rising edge of sck while sel_n is low shifts sdi into bit 0 of the shift register, and the older bits move toward bit 7. The word is therefore sent most significant bit first. Each sck level must be held for at least SYNC_STAGES+2 system clocks.
- R3: The wiper code does not change while bits are being shifted. It changes only after a low-to-high transition of sel_n.
- R4: On a low-to-high transition of sel_n, the wiper takes the current shift register contents. After exactly 8 bits, this is the word that was sent.
- R5: When more than 8 bits arrive in one select-low period, only the last 8 are kept and the earlier ones are dropped.
- R6: Edges on sck while sel_n is high leave both the shift register and the wiper code unchanged.
- R7: sdo_oe is high (drive low) exactly when bit 7 of the shift register is 0. As a result, the serial output repeats the input stream 8 shifts later.
- R8: tap_sel always has exactly one bit set, at the index equal to the wiper code. Code 0x00 sets bit 0, the end at terminal B, and code 0xFF sets bit 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than sck |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Serial select, active low |
| sck | input | 1 | Serial clock, sampled on its rising edge |
| sdi | input | 1 | Serial data in, MSB first |
| sdo_oe | output | 1 | Open-drain enable for the cascade output, high pulls the line low |
| wiper | output | 8 | Latched wiper code |
| tap_sel | output | 256 | One-hot tap select decoded from the wiper code |

## Verification
Random frames of 1 to 20 bits are mixed with directed words. Short frames show that the wiper takes the shifted register contents and not a zero-padded word. Long frames show that leading bits are dropped. The cascade output is compared bit by bit against a model of the register, so a wrong shift direction or a wrong output polarity shows up at once. Bursts of sck and sdi activity with select high, and the extreme codes 0x00 and 0xFF, separate correct gating and tap decoding from off-by-one or ungated logic.

// File: rtl/serial_wiper.sv
module serial_wiper #(
  parameter int CODE_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [CODE_W-1:0] PRESET = 8'h80
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sel_n,
  input  logic                      sck,
  input  logic                      sdi,
  output logic                      sdo_oe,
  output logic [CODE_W-1:0]         wiper,
  output logic [(1<<CODE_W)-1:0]    tap_sel
);
  localparam int TAPS = 1 << CODE_W;

  logic [SYNC_STAGES-1:0] sel_sync, sck_sync, sdi_sync;
  logic sel_q, sck_q;
  logic [CODE_W-1:0] shreg;

  wire sel_s = sel_sync[SYNC_STAGES-1];
  wire sck_s = sck_sync[SYNC_STAGES-1];
  wire sdi_s = sdi_sync[SYNC_STAGES-1];
  wire shift = sck_s & ~sck_q & ~sel_s;
  wire load  = sel_s & ~sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_sync <= '1;
      sck_sync <= '0;
      sdi_sync <= '0;
      sel_q    <= 1'b1;
      sck_q    <= 1'b0;
    end else begin
      sel_sync <= {sel_sync[SYNC_STAGES-2:0], sel_n};
      sck_sync <= {sck_sync[SYNC_STAGES-2:0], sck};
      sdi_sync <= {sdi_sync[SYNC_STAGES-2:0], sdi};
      sel_q    <= sel_s;
      sck_q    <= sck_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     shreg <= '1;
    else if (shift) shreg <= {shreg[CODE_W-2:0], sdi_s};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    wiper <= PRESET;
    else if (load) wiper <= shreg;
  end

  assign sdo_oe  = ~shreg[CODE_W-1];
  assign tap_sel = TAPS'(1) << wiper;

  AST_TAP_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tap_sel) == 1 && tap_sel[wiper]); // R8
  AST_WIPER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(wiper)); // R3
  AST_WIPER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> wiper == $past(shreg)); // R4
  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
    shift |=> shreg[0] == $past(sdi_s)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    sel_s |=> $stable(shreg)); // R6
endmodule

// File: tb/test_serial_wiper.sv
module test_serial_wiper;
  logic clk = 1'b0, rst_n = 1'b0, sel_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic sdo_oe;
  logic [7:0] wiper;
  logic [255:0] tap_sel;
  int errors = 0, checks = 0;
  logic done = 1'b0;
  logic [7:0] m_sh = 8'hFF, m_wip = 8'h80;

  always #4 clk = ~clk;

  serial_wiper i_serial_wiper (.clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sck(sck),
    .sdi(sdi), .sdo_oe(sdo_oe), .wiper(wiper), .tap_sel(tap_sel));

  function automatic logic [255:0] exp_tap(input logic [7:0] c);
    logic [255:0] t = '0;
    t[c] = 1'b1;
    return t;
  endfunction

  task automatic chk(input string req, input logic [255:0] got, input logic [255:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send(input int n, input logic [63:0] stream);
    sel_n = 1'b0;
    wait_clk(5);
    for (int i = 0; i < n; i++) begin
      sdi = stream[n-1-i];
      sck = 1'b0;
      wait_clk(5);
      chk("R7 sdo", {255'd0, ~sdo_oe}, {255'd0, m_sh[7]});
      sck = 1'b1;
      m_sh = {m_sh[6:0], stream[n-1-i]};
      wait_clk(5);
    end
    sck = 1'b0;
    wait_clk(5);
    chk("R3 wiper held while shifting", {248'd0, wiper}, {248'd0, m_wip});
    sel_n = 1'b1;
    m_wip = m_sh;
    wait_clk(10);
    chk("R4/R5 wiper after select rise", {248'd0, wiper}, {248'd0, m_wip});
    chk("R8 tap select", tap_sel, exp_tap(m_wip));
  endtask

  task automatic idle_noise(input int n);
    for (int i = 0; i < n; i++) begin
      sdi = 1'($urandom);
      sck = 1'b1; wait_clk(5);
      sck = 1'b0; wait_clk(5);
    end
    chk("R6 wiper unchanged by idle clocks", {248'd0, wiper}, {248'd0, m_wip});
    chk("R6 register unchanged by idle clocks", {255'd0, ~sdo_oe}, {255'd0, m_sh[7]});
  endtask

  initial begin
    void'($urandom(32'd20240611));
    wait_clk(3);
    chk("R1 reset wiper", {248'd0, wiper}, 256'h80);
    chk("R1 reset tap", tap_sel, exp_tap(8'h80));
    chk("R1 reset sdo_oe", {255'd0, sdo_oe}, 256'd0);
    rst_n = 1'b1;
    wait_clk(5);
    chk("R1 wiper after release", {248'd0, wiper}, 256'h80);
    send(8, 64'hA5);
    chk("R2 MSB first 0xA5", {248'd0, wiper}, 256'hA5);
    send(8, 64'h00);
    chk("R8 code 0 selects tap 0", tap_sel, 256'd1);
    send(8, 64'hFF);
    chk("R8 code 0xFF selects tap 255", tap_sel, {1'b1, 255'd0});
    send(16, 64'h3CC3);
    chk("R5 last 8 of 16 bits", {248'd0, wiper}, 256'hC3);
    idle_noise(6);
    send(3, 64'h5);
    send(8, 64'h17);
    idle_noise(3);
    for (int f = 0; f < 40; f++) begin
      send(1 + int'($urandom % 20), {$urandom, $urandom});
      if (f % 8 == 0) idle_noise(2);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule